// File: doc/BRIEF.md
# Stream-to-Memory Write Mover

This block takes a packed command word on a command channel and moves the matching stream payload into memory through an AXI4 write master. The command gives the byte count, the burst type, the start address, a 4-bit tag, an end-of-frame flag and, in the wide configuration, cache and user sideband values. The engine cuts the transfer into bursts of at most 16 beats of 64 bits. An incrementing burst never crosses a 4 KB page. For each burst it issues the address, then passes stream beats straight to the write channel, then waits for the write response.

When the last response is in, the engine presents one status byte that carries the command's tag and a summary of what went wrong. Only one command is handled at a time. A new command is not accepted until the status byte has been taken. Commands with a misaligned address or a bad length are answered with an error status and cause no bus traffic.

Top module: `strm2mem_mover`

## Requirements
- R1: Command fields: bits [22:0] are the byte count, bit 23 the burst type, bits [63:32] the 32-bit start address and bits [67:64] the tag. The tag comes back unchanged in status bits [3:0]. Bits [29:24] and bit 31 have no effect.
- R2: With an 80-bit command, bits [75:72] drive awCache and bits [79:76] drive awUser on every burst of that command. With a 72-bit command both are 0.
- R3: Every burst has at most 16 beats. awLen is the beat count minus 1 and awSize is 3 (8 bytes). The bursts together carry exactly byte count / 8 beats, each burst taking as many beats as the other rules allow.
- R4: When bit 23 is 1, bursts are incrementing (awBurst = 01). The first starts at the start address and each next one starts right after the previous one's last byte. No burst crosses a 4096-byte boundary.
- R5: When bit 23 is 0, bursts are fixed (awBurst = 00) and every burst targets the start address.
- R6: Stream beats pass to the write channel in order and unchanged. wStrb is 0xFF. wLast is high exactly on the final beat of each burst.
- R7: Status layout: bit 7 is OK, bit 6 is decode error, bit 5 is slave error, bit 4 is command/frame error, bits [3:0] are the tag. OK is 1 only when bits 6:4 are all 0.
- R8: A write response of 10 sets status bit 5, and a response of 11 sets bit 6. Either one, on any burst of the command, clears OK.
- R9: A start address that is not a multiple of 8, or a byte count that is 0 or not a multiple of 8, gives status bit 4 with no address, data or response traffic.
- R10: When the end-of-frame flag (bit 30) is 1 and the stream beat that completes the count lacks sLast, status bit 4 is set. With the flag at 0, sLast has no effect.
- R11: cmdReady is low from command acceptance until the status byte is accepted. stsValid and stsData hold steady until stsReady.
- R12: Address-channel outputs hold steady until awReady. Write data for a burst starts only after its address is accepted.
- R13: After reset, cmdReady is 1 and awValid, wValid, bReady and stsValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command valid |
| cmdReady | output | 1 | Command ready |
| cmdData | input | CMD_W | Packed command word (72 or 80 bits) |
| sValid | input | 1 | Payload stream valid |
| sReady | output | 1 | Payload stream ready |
| sData | input | 64 | Payload stream data |
| sLast | input | 1 | Payload stream end marker |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| awAddr | output | 32 | Burst start address |
| awLen | output | 8 | Beats in burst minus 1 |
| awSize | output | 3 | Beat size code |
| awBurst | output | 2 | Burst type |
| awCache | output | 4 | Cache attributes |
| awUser | output | 4 | User sideband |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| wData | output | 64 | Write data |
| wStrb | output | 8 | Byte strobes |
| wLast | output | 1 | Last beat of burst |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response ready |
| bResp | input | 2 | Write response code |
| stsValid | output | 1 | Status valid |
| stsReady | input | 1 | Status ready |
| stsData | output | 8 | Status byte |

## Verification
A wrong remaining-beat count or a wrong address register shows at the next address handshake: the burst has the wrong length or start, or it crosses a page. A bad in-burst counter moves wLast within the same burst. Sticky error flags that are not cleared, or a lost tag, show up in the very next status byte. Status bytes are held back for several cycles so that a status lost or rewritten while stalled, or a command accepted too early, appears at the status and command ports during the stall.

// File: rtl/strm2mem_pkg.sv
package strm2mem_pkg;

  // command word field positions (decoded by the datapath)
  localparam int LEN_W     = 23;
  localparam int BURST_BIT = 23;
  localparam int EOF_BIT   = 30;
  localparam int ADDR_LSB  = 32;
  localparam int ADDR_W    = 32;
  localparam int TAG_LSB   = 64;
  localparam int TAG_W     = 4;
  localparam int CACHE_LSB = 72;
  localparam int USER_LSB  = 76;
  localparam int SIDE_W    = 4;

  // status byte bit positions
  localparam int STS_OK  = 7;
  localparam int STS_DEC = 6;
  localparam int STS_SLV = 5;
  localparam int STS_CMD = 4;

  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] RESP_SLV    = 2'b10;
  localparam logic [1:0] RESP_DEC    = 2'b11;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_RESP,
    PH_REPORT
  } phase_t;

  typedef struct packed {
    logic load;
    logic awFire;
    logic wFire;
    logic bFire;
  } strobe_t;

endpackage

// File: rtl/strm2mem_ctrl.sv
module strm2mem_ctrl
  import strm2mem_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    inBad,
  input  logic    lastBeat,
  input  logic    lastBurst,
  input  logic    awReady,
  input  logic    sValid,
  input  logic    wReady,
  input  logic    bValid,
  input  logic    stsReady,
  output logic    cmdReady,
  output logic    awValid,
  output logic    wValid,
  output logic    sReady,
  output logic    bReady,
  output logic    stsValid,
  output strobe_t strobe
);

  phase_t stateQ, stateD;

  assign cmdReady = (stateQ == PH_IDLE);
  assign awValid  = (stateQ == PH_ADDR);
  assign wValid   = (stateQ == PH_DATA) && sValid;
  assign sReady   = (stateQ == PH_DATA) && wReady;
  assign bReady   = (stateQ == PH_RESP);
  assign stsValid = (stateQ == PH_REPORT);

  assign strobe.load   = cmdValid && cmdReady;
  assign strobe.awFire = awValid && awReady;
  assign strobe.wFire  = wValid && wReady;
  assign strobe.bFire  = bValid && bReady;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      PH_IDLE:   if (cmdValid) stateD = inBad ? PH_REPORT : PH_ADDR;
      PH_ADDR:   if (awReady) stateD = PH_DATA;
      PH_DATA:   if (strobe.wFire && lastBeat) stateD = PH_RESP;
      PH_RESP:   if (bValid) stateD = lastBurst ? PH_REPORT : PH_ADDR;
      PH_REPORT: if (stsReady) stateD = PH_IDLE;
      default:   stateD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= PH_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/strm2mem_dpath.sv
module strm2mem_dpath
  import strm2mem_pkg::*;
#(
  parameter int CMD_W     = 72,
  parameter int DATA_W    = 64,
  parameter int MAX_BEATS = 16,
  parameter int BOUNDARY  = 4096
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [CMD_W-1:0]    cmdData,
  input  logic                sLast,
  input  logic [1:0]          bResp,
  output logic                inBad,
  output logic                lastBeat,
  output logic                lastBurst,
  output logic [ADDR_W-1:0]   awAddr,
  output logic [7:0]          awLen,
  output logic [1:0]          awBurst,
  output logic [SIDE_W-1:0]   awCache,
  output logic [SIDE_W-1:0]   awUser,
  output logic [7:0]          stsData
);

  localparam int BYTES      = DATA_W / 8;
  localparam int SIZE_W     = $clog2(BYTES);
  localparam int BEAT_W     = LEN_W - SIZE_W;
  localparam int CNT_W      = $clog2(MAX_BEATS + 1);
  localparam int BND_W      = $clog2(BOUNDARY);
  localparam int PAGE_BEATS = BOUNDARY / BYTES;

  // incoming command fields
  logic [LEN_W-1:0]  lenIn;
  logic [ADDR_W-1:0] addrIn;
  logic [TAG_W-1:0]  tagIn;
  logic [SIDE_W-1:0] cacheIn, userIn;

  assign lenIn  = cmdData[LEN_W-1:0];
  assign addrIn = cmdData[ADDR_LSB +: ADDR_W];
  assign tagIn  = cmdData[TAG_LSB +: TAG_W];

  generate
    if (CMD_W >= USER_LSB + SIDE_W) begin : gWide
      assign cacheIn = cmdData[CACHE_LSB +: SIDE_W];
      assign userIn  = cmdData[USER_LSB +: SIDE_W];
    end else begin : gNarrow
      assign cacheIn = '0;
      assign userIn  = '0;
    end
  endgenerate

  // alignment and realignment-request fields have no effect here
  logic unusedCmd;
  assign unusedCmd = ^{cmdData[EOF_BIT-1:BURST_BIT+1], cmdData[EOF_BIT+1],
                       cmdData[TAG_LSB+TAG_W +: 4]};

  assign inBad = (lenIn == '0) || (lenIn[SIZE_W-1:0] != '0) ||
                 (addrIn[SIZE_W-1:0] != '0);

  // per-command state
  logic [ADDR_W-1:0] addrQ;
  logic [BEAT_W-1:0] remQ;
  logic [CNT_W-1:0]  leftQ;
  logic [TAG_W-1:0]  tagQ;
  logic [SIDE_W-1:0] cacheQ, userQ;
  logic              incrQ, eofQ;
  logic              badQ, slvQ, decQ;

  // burst sizing: limited by max beats, remaining beats and page room
  logic [BEAT_W-1:0] pageRoom, cap, beats;

  assign pageRoom = BEAT_W'(PAGE_BEATS) - BEAT_W'(addrQ[BND_W-1:SIZE_W]);
  assign cap      = (incrQ && (pageRoom < BEAT_W'(MAX_BEATS))) ? pageRoom
                                                               : BEAT_W'(MAX_BEATS);
  assign beats    = (remQ < cap) ? remQ : cap;

  assign awAddr    = addrQ;
  assign awLen     = 8'(beats - BEAT_W'(1));
  assign awBurst   = incrQ ? BURST_INCR : BURST_FIXED;
  assign awCache   = cacheQ;
  assign awUser    = userQ;
  assign lastBeat  = (leftQ == CNT_W'(1));
  assign lastBurst = (remQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      remQ   <= '0;
      leftQ  <= '0;
      tagQ   <= '0;
      cacheQ <= '0;
      userQ  <= '0;
      incrQ  <= 1'b0;
      eofQ   <= 1'b0;
      badQ   <= 1'b0;
      slvQ   <= 1'b0;
      decQ   <= 1'b0;
    end else begin
      if (strobe.load) begin
        addrQ  <= addrIn;
        remQ   <= lenIn[LEN_W-1:SIZE_W];
        tagQ   <= tagIn;
        cacheQ <= cacheIn;
        userQ  <= userIn;
        incrQ  <= cmdData[BURST_BIT];
        eofQ   <= cmdData[EOF_BIT];
        badQ   <= inBad;
        slvQ   <= 1'b0;
        decQ   <= 1'b0;
      end
      if (strobe.awFire) begin
        leftQ <= CNT_W'(beats);
        remQ  <= remQ - beats;
        if (incrQ) addrQ <= addrQ + (ADDR_W'(beats) << SIZE_W);
      end
      if (strobe.wFire) begin
        leftQ <= leftQ - CNT_W'(1);
        if (lastBeat && lastBurst && eofQ && !sLast) badQ <= 1'b1;
      end
      if (strobe.bFire) begin
        if (bResp == RESP_SLV) slvQ <= 1'b1;
        if (bResp == RESP_DEC) decQ <= 1'b1;
      end
    end
  end

  always_comb begin
    stsData          = '0;
    stsData[TAG_W-1:0] = tagQ;
    stsData[STS_CMD] = badQ;
    stsData[STS_SLV] = slvQ;
    stsData[STS_DEC] = decQ;
    stsData[STS_OK]  = !(badQ || slvQ || decQ);
  end

endmodule

// File: rtl/strm2mem_mover.sv
module strm2mem_mover
  import strm2mem_pkg::*;
#(
  parameter int CMD_W     = 72,
  parameter int DATA_W    = 64,
  parameter int MAX_BEATS = 16,
  parameter int BOUNDARY  = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [CMD_W-1:0]  cmdData,
  input  logic              sValid,
  output logic              sReady,
  input  logic [DATA_W-1:0] sData,
  input  logic              sLast,
  output logic              awValid,
  input  logic              awReady,
  output logic [31:0]       awAddr,
  output logic [7:0]        awLen,
  output logic [2:0]        awSize,
  output logic [1:0]        awBurst,
  output logic [3:0]        awCache,
  output logic [3:0]        awUser,
  output logic              wValid,
  input  logic              wReady,
  output logic [DATA_W-1:0] wData,
  output logic [DATA_W/8-1:0] wStrb,
  output logic              wLast,
  input  logic              bValid,
  output logic              bReady,
  input  logic [1:0]        bResp,
  output logic              stsValid,
  input  logic              stsReady,
  output logic [7:0]        stsData
);

  localparam int BYTES  = DATA_W / 8;
  localparam int SIZE_W = $clog2(BYTES);

  strobe_t strobe;
  logic    inBad, lastBeat, lastBurst;

  strm2mem_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .inBad    (inBad),
    .lastBeat (lastBeat),
    .lastBurst(lastBurst),
    .awReady  (awReady),
    .sValid   (sValid),
    .wReady   (wReady),
    .bValid   (bValid),
    .stsReady (stsReady),
    .cmdReady (cmdReady),
    .awValid  (awValid),
    .wValid   (wValid),
    .sReady   (sReady),
    .bReady   (bReady),
    .stsValid (stsValid),
    .strobe   (strobe)
  );

  strm2mem_dpath #(
    .CMD_W    (CMD_W),
    .DATA_W   (DATA_W),
    .MAX_BEATS(MAX_BEATS),
    .BOUNDARY (BOUNDARY)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdData  (cmdData),
    .sLast    (sLast),
    .bResp    (bResp),
    .inBad    (inBad),
    .lastBeat (lastBeat),
    .lastBurst(lastBurst),
    .awAddr   (awAddr),
    .awLen    (awLen),
    .awBurst  (awBurst),
    .awCache  (awCache),
    .awUser   (awUser),
    .stsData  (stsData)
  );

  assign awSize = 3'(SIZE_W);
  assign wData  = sData;
  assign wStrb  = '1;
  assign wLast  = lastBeat;

endmodule

// File: rtl/strm2mem_mover_chk.sv
module strm2mem_mover_chk #(
  parameter int DATA_W    = 64,
  parameter int MAX_BEATS = 16,
  parameter int BOUNDARY  = 4096
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdReady,
  input logic                awValid,
  input logic                awReady,
  input logic [31:0]         awAddr,
  input logic [7:0]          awLen,
  input logic [1:0]          awBurst,
  input logic                wValid,
  input logic                wReady,
  input logic                wLast,
  input logic [DATA_W/8-1:0] wStrb,
  input logic                stsValid,
  input logic                stsReady,
  input logic [7:0]          stsData
);

  localparam int BYTES = DATA_W / 8;
  localparam int BND_W = $clog2(BOUNDARY);

  logic [7:0] lenQ, cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ <= '0;
      cntQ <= '0;
    end else begin
      if (awValid && awReady) lenQ <= awLen;
      if (wValid && wReady) cntQ <= wLast ? 8'd0 : cntQ + 8'd1;
    end
  end

  // R11
  sts_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    stsValid |-> !cmdReady);

  // R11
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stsValid && !stsReady |=> stsValid && $stable(stsData));

  // R12
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> awValid && $stable(awAddr) && $stable(awLen) && $stable(awBurst));

  // R12
  aw_w_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> !wValid);

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> (int'(awLen) < MAX_BEATS));

  // R4
  page_cross_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid && (awBurst == 2'b01) |->
      (int'(awAddr[BND_W-1:0]) + (int'(awLen) + 1) * BYTES) <= BOUNDARY);

  // R6
  strb_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> (wStrb == '1));

  // R6
  wlast_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid && wReady |-> (wLast == (cntQ == lenQ)));

  // R7
  sts_ok_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    stsValid && stsData[7] |-> (stsData[6:4] == 3'b000));

endmodule

bind strm2mem_mover strm2mem_mover_chk #(
  .DATA_W   (DATA_W),
  .MAX_BEATS(MAX_BEATS),
  .BOUNDARY (BOUNDARY)
) chk (
  .clk     (clk),
  .rstN    (rstN),
  .cmdReady(cmdReady),
  .awValid (awValid),
  .awReady (awReady),
  .awAddr  (awAddr),
  .awLen   (awLen),
  .awBurst (awBurst),
  .wValid  (wValid),
  .wReady  (wReady),
  .wLast   (wLast),
  .wStrb   (wStrb),
  .stsValid(stsValid),
  .stsReady(stsReady),
  .stsData (stsData)
);

// File: tb/strm2mem_mover_test.sv
module strm2mem_mover_test;

  localparam int CMD_W = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic             cmdValid = 1'b0, cmdReady;
  logic [CMD_W-1:0] cmdData = '0;
  logic             sValid = 1'b0, sReady, sLast = 1'b0;
  logic [63:0]      sData = '0;
  logic             awValid, awReady = 1'b0;
  logic [31:0]      awAddr;
  logic [7:0]       awLen;
  logic [2:0]       awSize;
  logic [1:0]       awBurst;
  logic [3:0]       awCache, awUser;
  logic             wValid, wReady = 1'b0, wLast;
  logic [63:0]      wData;
  logic [7:0]       wStrb;
  logic             bValid = 1'b0, bReady;
  logic [1:0]       bResp = 2'b00;
  logic             stsValid, stsReady = 1'b0;
  logic [7:0]       stsData;

  strm2mem_mover #(.CMD_W(CMD_W)) uut (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
    .sValid(sValid), .sReady(sReady), .sData(sData), .sLast(sLast),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awLen(awLen),
    .awSize(awSize), .awBurst(awBurst), .awCache(awCache), .awUser(awUser),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .stsValid(stsValid), .stsReady(stsReady), .stsData(stsData)
  );

  typedef struct {
    logic [31:0] addr;
    logic [7:0]  len;
    logic [1:0]  burst;
    logic [3:0]  cache;
    logic [3:0]  user;
  } awItem_t;

  typedef struct {
    logic [63:0] data;
    logic        last;
  } wItem_t;

  typedef struct {
    logic [7:0] sts;
    string      req;
  } stsItem_t;

  awItem_t     expAw[$];
  wItem_t      expW[$];
  stsItem_t    expSts[$];
  logic [63:0] srcData[$];
  logic        srcLast[$];
  logic [1:0]  respQ[$];

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int pendB = 0;
  int stsWait = 0;
  int stsSeen = 0;
  int seq = 0;
  bit stall = 0;
  bit stsHeld = 0;
  logic [7:0] stsPrev = '0;
  bit awHeld = 0;
  logic [31:0] awPrevAddr = '0;
  logic [7:0]  awPrevLen = '0;

  function automatic void check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  // slave model and monitor: drive at negedge, observe 1 ns before posedge
  always begin
    @(negedge clk);
    cyc++;
    awReady = stall ? (cyc % 3 != 0) : 1'b1;
    wReady  = stall ? (cyc % 4 != 1) : 1'b1;
    sValid  = (srcData.size() > 0) && (!stall || (cyc % 5 != 2));
    sData   = (srcData.size() > 0) ? srcData[0] : 64'h0;
    sLast   = (srcLast.size() > 0) ? srcLast[0] : 1'b0;
    bValid  = (pendB > 0);
    bResp   = (pendB > 0 && respQ.size() > 0) ? respQ[0] : 2'b00;
    stsReady = (stsWait >= 3);
    #1;
    if (rstN) begin
      if (stsValid) check(!cmdReady, "R11 cmdReady during status", 64'(cmdReady), 64'h0);
      if (stsHeld) check(stsValid && stsData == stsPrev, "R11 status hold",
                         64'(stsData), 64'(stsPrev));
      if (awHeld) check(awValid && awAddr == awPrevAddr && awLen == awPrevLen,
                        "R12 address hold", 64'(awAddr), 64'(awPrevAddr));
      awHeld = awValid && !awReady;
      awPrevAddr = awAddr;
      awPrevLen = awLen;
      if (awValid && awReady) begin
        if (expAw.size() == 0) begin
          check(1'b0, "R9 unexpected address traffic", 64'(awAddr), 64'h0);
        end else begin
          awItem_t e;
          e = expAw.pop_front();
          check(awAddr == e.addr, (e.burst == 2'b01) ? "R4 burst address" : "R5 burst address",
                64'(awAddr), 64'(e.addr));
          check(awLen == e.len, "R3 burst length", 64'(awLen), 64'(e.len));
          check(awSize == 3'd3, "R3 burst size", 64'(awSize), 64'd3);
          check(awBurst == e.burst, "R5 burst type", 64'(awBurst), 64'(e.burst));
          check(awCache == e.cache && awUser == e.user, "R2 cache/user",
                64'({awCache, awUser}), 64'({e.cache, e.user}));
        end
      end
      if (wValid && wReady) begin
        if (expW.size() == 0) begin
          check(1'b0, "R9 unexpected data traffic", wData, 64'h0);
        end else begin
          wItem_t w;
          w = expW.pop_front();
          check(wData == w.data, "R6 data order", wData, w.data);
          check(wLast == w.last, "R6 wLast position", 64'(wLast), 64'(w.last));
          check(wStrb == 8'hFF, "R6 strobes", 64'(wStrb), 64'hFF);
          if (wLast) pendB++;
        end
        void'(srcData.pop_front());
        void'(srcLast.pop_front());
      end
      if (bValid && bReady) begin
        void'(respQ.pop_front());
        pendB--;
      end
      if (stsValid && stsReady) begin
        if (expSts.size() == 0) begin
          check(1'b0, "R7 unexpected status", 64'(stsData), 64'h0);
        end else begin
          stsItem_t s;
          s = expSts.pop_front();
          check(stsData == s.sts, s.req, 64'(stsData), 64'(s.sts));
          check(stsData[3:0] == s.sts[3:0], "R1 tag echo", 64'(stsData[3:0]), 64'(s.sts[3:0]));
        end
        stsWait = 0;
        stsSeen++;
        stsHeld = 0;
      end else if (stsValid) begin
        stsWait++;
        stsHeld = 1;
        stsPrev = stsData;
      end else begin
        stsHeld = 0;
      end
    end
  end

  task automatic runCmd(input logic [31:0] addr, input logic [22:0] bytes, input bit incr,
                        input bit eof, input bit tlastOk, input logic [3:0] tag,
                        input logic [3:0] cache, input logic [3:0] user,
                        input logic [1:0] r0, input logic [1:0] r1, input string req);
    bit bad;
    bit slv, dec, frm;
    int rem, idx, startSeen;
    logic [31:0] a;
    stsItem_t s;
    bad = (bytes == 0) || (bytes % 8 != 0) || (addr % 8 != 0);
    slv = 0; dec = 0;
    frm = bad || (eof && !tlastOk);
    if (!bad) begin
      rem = int'(bytes) / 8;
      a = addr;
      idx = 0;
      while (rem > 0) begin
        int n, room;
        awItem_t e;
        logic [1:0] r;
        room = incr ? (4096 - int'(a % 4096)) / 8 : 16;
        n = (rem < 16) ? rem : 16;
        if (room < n) n = room;
        e.addr = a; e.len = 8'(n - 1); e.burst = incr ? 2'b01 : 2'b00;
        e.cache = cache; e.user = user;
        expAw.push_back(e);
        for (int k = 0; k < n; k++) begin
          wItem_t w;
          logic [63:0] d;
          d = {tag, 28'h0, 32'(seq)};
          seq++;
          w.data = d; w.last = (k == n - 1);
          expW.push_back(w);
          srcData.push_back(d);
          srcLast.push_back((rem == n && k == n - 1) ? tlastOk : 1'b0);
        end
        r = (idx == 0) ? r0 : (idx == 1) ? r1 : 2'b00;
        if (r == 2'b10) slv = 1;
        if (r == 2'b11) dec = 1;
        respQ.push_back(r);
        if (incr) a = a + 32'(n * 8);
        rem -= n;
        idx++;
      end
    end
    s.sts = {!(slv || dec || frm), dec, slv, frm, tag};
    s.req = req;
    expSts.push_back(s);
    startSeen = stsSeen;
    @(negedge clk);
    cmdValid = 1'b1;
    // bits 31 and 29:24 carry junk that must have no effect (R1)
    cmdData = {user, cache, 4'h0, tag, addr, 1'b1, eof, 6'h2A, incr, bytes};
    forever begin
      #1;
      if (cmdReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    cmdValid = 1'b0;
    cmdData = '0;
    wait (stsSeen == startSeen + 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'(cyc), 64'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R13 reset state
    check(cmdReady == 1'b1, "R13 cmdReady after reset", 64'(cmdReady), 64'h1);
    check(!awValid && !wValid && !bReady && !stsValid, "R13 idle outputs after reset",
          64'({awValid, wValid, bReady, stsValid}), 64'h0);

    // R1 R3 R4: two full incrementing bursts
    runCmd(32'h1000_0000, 23'd256, 1'b1, 1'b0, 1'b1, 4'h5, 4'h0, 4'h0, 2'b00, 2'b00, "R7 ok status");
    // R4: page boundary split 8 + 16 + 1 with back-pressure
    stall = 1;
    runCmd(32'h0000_0FC0, 23'd200, 1'b1, 1'b0, 1'b1, 4'hA, 4'h0, 4'h0, 2'b00, 2'b00, "R4 boundary split status");
    // R5: fixed bursts 16 + 4 at one address
    runCmd(32'h2000_0040, 23'd160, 1'b0, 1'b0, 1'b1, 4'h3, 4'h0, 4'h0, 2'b00, 2'b00, "R5 fixed status");
    // R8: slave error on the second burst
    runCmd(32'h3000_0000, 23'd192, 1'b1, 1'b0, 1'b1, 4'h7, 4'h0, 4'h0, 2'b00, 2'b10, "R8 slave error status");
    stall = 0;
    // R8: decode error on a single burst
    runCmd(32'h3000_1000, 23'd64, 1'b1, 1'b0, 1'b1, 4'h9, 4'h0, 4'h0, 2'b11, 2'b00, "R8 decode error status");
    // R9: bad commands give error status with no traffic
    runCmd(32'h4000_0004, 23'd64, 1'b1, 1'b0, 1'b1, 4'h1, 4'h0, 4'h0, 2'b00, 2'b00, "R9 misaligned address");
    runCmd(32'h4000_0000, 23'd12, 1'b1, 1'b0, 1'b1, 4'h2, 4'h0, 4'h0, 2'b00, 2'b00, "R9 odd length");
    runCmd(32'h4000_0000, 23'd0, 1'b1, 1'b0, 1'b1, 4'h4, 4'h0, 4'h0, 2'b00, 2'b00, "R9 zero length");
    // R10: end of frame with and without the final marker
    runCmd(32'h5000_0000, 23'd48, 1'b1, 1'b1, 1'b0, 4'hB, 4'h0, 4'h0, 2'b00, 2'b00, "R10 missing end marker");
    runCmd(32'h5000_0100, 23'd48, 1'b1, 1'b1, 1'b1, 4'hC, 4'h0, 4'h0, 2'b00, 2'b00, "R10 end marker present");
    // R10: flag clear, marker absent has no effect
    runCmd(32'h5000_0200, 23'd16, 1'b1, 1'b0, 1'b0, 4'hD, 4'h0, 4'h0, 2'b00, 2'b00, "R10 flag clear");
    // R2: cache and user sideband
    runCmd(32'h6000_0000, 23'd144, 1'b1, 1'b0, 1'b1, 4'hE, 4'h6, 4'h9, 2'b00, 2'b00, "R2 sideband status");

    check(expAw.size() == 0, "R3 all bursts issued", 64'(expAw.size()), 64'h0);
    check(expW.size() == 0, "R6 all beats moved", 64'(expW.size()), 64'h0);
    check(expSts.size() == 0, "R7 all status returned", 64'(expSts.size()), 64'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule